// File: doc/BRIEF.md
# Per-Operation Rounding Float-to-Integer Converter

This block turns IEEE 754 floating-point values into two's-complement signed integers. Each operation brings its own rounding choice in a 3-bit code, so no shared control state exists. Callers can change the rounding direction on every cycle at no cost. The operand is either single or double precision, and one operation carries one, two or four lanes.

Two codes go beyond plain directed rounding. The exact code rounds to nearest-even and raises an exception whenever a lane loses fraction bits. An integer-only fast path can then hand the rare inexact case to a slow handler. The mixed code gives each lane its own direction, so a single operation yields both the lower and the upper bound of an interval. The result, its flags and a valid bit are registered and appear one cycle after the operation is presented.

Top module: `f2i_convert`

## Requirements
- R1: Mode code 000 rounds to nearest with ties to even. This is the default direction: 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R2: Mode code 001 truncates toward zero: 2.75 gives 2 and -2.75 gives -2.
- R3: Mode code 010 rounds toward positive infinity and code 011 rounds toward negative infinity. With 010, 2.25 gives 3 and -2.25 gives -2. With 011 they give 2 and -3.
- R4: Mode code 100 rounds to nearest with ties away from zero: 2.5 gives 3 and -2.5 gives -3.
- R5: Mode code 101 rounds like code 000. out_except is set exactly when at least one active lane is inexact: 2.5 raises it and 2.0 does not.
- R6: Mode code 110 picks a direction per lane. With two lanes, lane 0 rounds toward negative infinity and lane 1 toward positive infinity. With four lanes, lanes 0, 1, 2 and 3 use toward negative infinity, nearest-even, toward positive infinity and toward zero. A single lane rounds toward negative infinity.
- R7: out_inexact is the OR over active, non-invalid lanes of "fraction bits were discarded", in every mode. out_except is never set by codes 000 to 100 or 110 when the lane count is legal.
- R8: NaN, infinity, or a finite value whose rounded result falls outside [-2^(OUT_W-1), 2^(OUT_W-1)-1] sets out_invalid. The lane saturates to 2^(OUT_W-1)-1 when the sign bit is 0 and to -2^(OUT_W-1) when it is 1. Such a lane adds nothing to out_inexact. -2^(OUT_W-1) itself converts without error.
- R9: Mode code 111, or a lane-count code above log2(MAX_LANES), is illegal. It sets out_except, forces every result lane to 0 and clears out_inexact and out_invalid.
- R10: in_dbl=1 reads each 64-bit lane slot (lane i at bits [64i+63:64i]) as double precision. in_dbl=0 reads bits [64i+31:64i] of the slot as single precision. Result lane i sits at out_int bits [OUT_W*i+OUT_W-1:OUT_W*i].
- R11: A lane-count code k activates lanes 0 to 2^k-1. Inactive lanes output 0 and set no flag.
- R12: out_valid follows in_valid one cycle later, with the results and flags of that operation. In a cycle after in_valid was low, the flags are 0 and out_int keeps its previous value.
- R13: While rst_n is low, out_valid, out_int and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_mode | input | 3 | Rounding code of this operation |
| in_lanes | input | LC_W | Lane-count code k, 2^k active lanes |
| in_dbl | input | 1 | 1 double precision, 0 single precision |
| in_opnd | input | MAX_LANES*64 | Operand lane slots |
| out_valid | output | 1 | Result present |
| out_int | output | MAX_LANES*OUT_W | Signed integer lanes |
| out_inexact | output | 1 | Some active lane discarded fraction bits |
| out_invalid | output | 1 | Some active lane was NaN, infinite or out of range |
| out_except | output | 1 | Exact-mode inexact, or illegal operation |

## Verification
A wrong per-lane direction, for example a mixed-mode lane mapped to the wrong rounding, shows only on lanes whose operand has a fraction. It is visible on the first valid result after the operation, and only for the affected lane. A bad sticky or round bit from the alignment shifter shows up as an off-by-one integer on tie or near-tie inputs, usually together with a wrong out_inexact in the same cycle. A range-limit error shows as a missing saturation or a spurious out_invalid one cycle after inputs near ±2^(OUT_W-1), so the bench drives tie values at both ends of the range.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
   // rounding codes carried with each operation
   typedef enum logic [2:0] {
      RM_NEAR  = 3'b000,
      RM_ZERO  = 3'b001,
      RM_PINF  = 3'b010,
      RM_NINF  = 3'b011,
      RM_AWAY  = 3'b100,
      RM_EXACT = 3'b101,
      RM_MIXED = 3'b110,
      RM_BAD   = 3'b111
   } rmode_e;

   localparam int OPND_W   = 64;
   localparam int DP_EXP_W = 11;
   localparam int DP_MAN_W = 52;
   localparam int SP_EXP_W = 8;
   localparam int SP_MAN_W = 23;
   localparam int DP_BIAS  = 1023;
   localparam int SP_BIAS  = 127;
   localparam int WIDE_W   = 64;
endpackage

// File: rtl/f2i_lane_mode.sv
`timescale 1ns/1ps
module f2i_lane_mode
   import f2i_pkg::*;
#(
   parameter int LANE_IDX   = 0,
   parameter int LOG2_LANES = 2,
   parameter int LC_W       = 2
) (
   input  rmode_e          op_mode,
   input  logic [LC_W-1:0] lane_code,
   output rmode_e          lane_mode,
   output logic            lane_on
);
   // fixed direction of this lane under the mixed code
   localparam rmode_e PAIR_MODE = (LANE_IDX % 2 == 0) ? RM_NINF : RM_PINF;
   localparam rmode_e QUAD_MODE = (LANE_IDX % 4 == 0) ? RM_NINF :
                                  (LANE_IDX % 4 == 1) ? RM_NEAR :
                                  (LANE_IDX % 4 == 2) ? RM_PINF : RM_ZERO;

   logic code_ok;

   assign code_ok = int'(lane_code) <= LOG2_LANES;
   assign lane_on = code_ok && ((LANE_IDX >> lane_code) == 0);

   always_comb begin
      case (op_mode)
         RM_EXACT: lane_mode = RM_NEAR;
         RM_MIXED: lane_mode = (int'(lane_code) == 1) ? PAIR_MODE : QUAD_MODE;
         RM_BAD:   lane_mode = RM_NEAR;
         default:  lane_mode = op_mode;
      endcase
   end
endmodule

// File: rtl/f2i_lane_cvt.sv
`timescale 1ns/1ps
module f2i_lane_cvt
   import f2i_pkg::*;
#(
   parameter int OUT_W = 32
) (
   input  logic [OPND_W-1:0] opnd,
   input  logic              is_dbl,
   input  rmode_e            rm,
   output logic [OUT_W-1:0]  res,
   output logic              inexact,
   output logic              invalid
);
   localparam int SH_W = $clog2(WIDE_W);
   localparam logic [WIDE_W-1:0] NEG_LIM = WIDE_W'(1) << (OUT_W - 1);
   localparam logic [WIDE_W-1:0] POS_LIM = NEG_LIM - WIDE_W'(1);
   localparam logic [OUT_W-1:0]  SAT_POS = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0]  SAT_NEG = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic signed [12:0] OUT_LIM = 13'(OUT_W);
   localparam logic signed [12:0] MAN_POS = 13'(DP_MAN_W);
   localparam logic signed [12:0] SH_MAX  = 13'(WIDE_W - 1);

   logic                  sgn;
   logic [DP_EXP_W-1:0]   expf;
   logic [DP_EXP_W-1:0]   exp_top;
   logic [DP_MAN_W-1:0]   man;
   logic signed [12:0]    bias;
   logic signed [12:0]    e_unb;
   logic signed [12:0]    sh_full;
   logic                  special;
   logic                  subn;
   logic                  big;
   logic [SH_W-1:0]       shc;
   logic [WIDE_W-1:0]     sig;
   logic [WIDE_W-1:0]     mag;
   logic [WIDE_W-1:0]     magr;
   logic [WIDE_W-1:0]     below;
   logic                  rnd;
   logic                  stk;
   logic                  inc;
   logic                  ovf;

   // unpack into a common double-width layout
   always_comb begin
      if (is_dbl) begin
         sgn     = opnd[OPND_W-1];
         expf    = opnd[DP_MAN_W +: DP_EXP_W];
         man     = opnd[DP_MAN_W-1:0];
         exp_top = '1;
         bias    = 13'(DP_BIAS);
      end else begin
         sgn     = opnd[SP_EXP_W + SP_MAN_W];
         expf    = DP_EXP_W'(opnd[SP_MAN_W +: SP_EXP_W]);
         man     = {opnd[SP_MAN_W-1:0], {(DP_MAN_W-SP_MAN_W){1'b0}}};
         exp_top = DP_EXP_W'({SP_EXP_W{1'b1}});
         bias    = 13'(SP_BIAS);
      end
   end

   assign special = (expf == exp_top);
   assign subn    = (expf == '0);
   assign e_unb   = subn ? (13'sd1 - bias) : ($signed({2'b00, expf}) - bias);
   assign big     = (e_unb > OUT_LIM);
   assign sh_full = MAN_POS - e_unb;

   // alignment shift, clamped so tiny values only feed the sticky bit
   always_comb begin
      if (big)                  shc = '0;
      else if (sh_full > SH_MAX) shc = '1;
      else                       shc = sh_full[SH_W-1:0];
   end

   assign sig   = {{(WIDE_W-DP_MAN_W-1){1'b0}}, ~subn, man};
   assign mag   = sig >> shc;
   assign rnd   = (shc != '0) ? sig[shc - SH_W'(1)] : 1'b0;
   assign below = (shc > SH_W'(1)) ? ((WIDE_W'(1) << (shc - SH_W'(1))) - WIDE_W'(1)) : '0;
   assign stk   = |(sig & below);

   always_comb begin
      case (rm)
         RM_ZERO: inc = 1'b0;
         RM_PINF: inc = ~sgn & (rnd | stk);
         RM_NINF: inc = sgn & (rnd | stk);
         RM_AWAY: inc = rnd;
         default: inc = rnd & (stk | mag[0]);
      endcase
   end

   assign magr    = mag + WIDE_W'(inc);
   assign ovf     = big | (magr > (sgn ? NEG_LIM : POS_LIM));
   assign invalid = special | ovf;
   assign inexact = ~invalid & (rnd | stk);

   always_comb begin
      if (invalid)  res = sgn ? SAT_NEG : SAT_POS;
      else if (sgn) res = -magr[OUT_W-1:0];
      else          res = magr[OUT_W-1:0];
   end
endmodule

// File: rtl/f2i_out_stage.sv
`timescale 1ns/1ps
module f2i_out_stage #(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_int,
   input  logic              d_inexact,
   input  logic              d_invalid,
   input  logic              d_except,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_int,
   output logic              q_inexact,
   output logic              q_invalid,
   output logic              q_except
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid   <= 1'b0;
         q_int     <= '0;
         q_inexact <= 1'b0;
         q_invalid <= 1'b0;
         q_except  <= 1'b0;
      end else begin
         q_valid   <= d_valid;
         q_inexact <= d_valid & d_inexact;
         q_invalid <= d_valid & d_invalid;
         q_except  <= d_valid & d_except;
         if (d_valid) q_int <= d_int;
      end
   end
endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
module f2i_convert
   import f2i_pkg::*;
#(
   parameter int  MAX_LANES  = 4,
   parameter int  OUT_W      = 32,
   localparam int LOG2_LANES = $clog2(MAX_LANES),
   localparam int LC_W       = $clog2(LOG2_LANES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [2:0]                  in_mode,
   input  logic [LC_W-1:0]             in_lanes,
   input  logic                        in_dbl,
   input  logic [MAX_LANES*OPND_W-1:0] in_opnd,
   output logic                        out_valid,
   output logic [MAX_LANES*OUT_W-1:0]  out_int,
   output logic                        out_inexact,
   output logic                        out_invalid,
   output logic                        out_except
);
   localparam int RES_W = MAX_LANES * OUT_W;

   initial begin : param_chk
      if (MAX_LANES < 2 || (1 << LOG2_LANES) != MAX_LANES)
         $error("f2i_convert: MAX_LANES must be a power of two, at least 2");
      if (OUT_W < 8 || OUT_W > DP_MAN_W)
         $error("f2i_convert: OUT_W must lie in 8..52");
   end

   rmode_e               op_mode;
   logic                 lanes_ok;
   logic                 op_bad;
   logic [RES_W-1:0]     lane_res;
   logic [MAX_LANES-1:0] lane_inx;
   logic [MAX_LANES-1:0] lane_inv;
   logic                 any_inx;
   logic                 any_inv;
   logic                 exc;

   assign op_mode  = rmode_e'(in_mode);
   assign lanes_ok = int'(in_lanes) <= LOG2_LANES;
   assign op_bad   = (op_mode == RM_BAD) || !lanes_ok;

   for (genvar gi = 0; gi < MAX_LANES; gi++) begin : g_lane
      rmode_e           rm;
      logic             on;
      logic [OUT_W-1:0] r;
      logic             ix;
      logic             iv;

      f2i_lane_mode #(
         .LANE_IDX  (gi),
         .LOG2_LANES(LOG2_LANES),
         .LC_W      (LC_W)
      ) u_mode (
         .op_mode  (op_mode),
         .lane_code(in_lanes),
         .lane_mode(rm),
         .lane_on  (on)
      );

      f2i_lane_cvt #(
         .OUT_W(OUT_W)
      ) u_cvt (
         .opnd   (in_opnd[gi*OPND_W +: OPND_W]),
         .is_dbl (in_dbl),
         .rm     (rm),
         .res    (r),
         .inexact(ix),
         .invalid(iv)
      );

      assign lane_res[gi*OUT_W +: OUT_W] = (on && !op_bad) ? r : '0;
      assign lane_inx[gi] = on & ~op_bad & ix;
      assign lane_inv[gi] = on & ~op_bad & iv;
   end

   assign any_inx = |lane_inx;
   assign any_inv = |lane_inv;
   assign exc     = op_bad | ((op_mode == RM_EXACT) & any_inx);

   f2i_out_stage #(
      .DATA_W(RES_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_valid  (in_valid),
      .d_int    (lane_res),
      .d_inexact(any_inx),
      .d_invalid(any_inv),
      .d_except (exc),
      .q_valid  (out_valid),
      .q_int    (out_int),
      .q_inexact(out_inexact),
      .q_invalid(out_invalid),
      .q_except (out_except)
   );
endmodule

// File: rtl/f2i_convert_chk.sv
`timescale 1ns/1ps
module f2i_convert_chk #(
   parameter int MAX_LANES = 4,
   parameter int OUT_W     = 32,
   parameter int LC_W      = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic [2:0]                 in_mode,
   input logic [LC_W-1:0]            in_lanes,
   input logic                       out_valid,
   input logic [MAX_LANES*OUT_W-1:0] out_int,
   input logic                       out_inexact,
   input logic                       out_invalid,
   input logic                       out_except
);
   localparam int LOG2_LANES = $clog2(MAX_LANES);

   logic legal_cnt;
   assign legal_cnt = int'(in_lanes) <= LOG2_LANES;

   p_valid_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_int));

   p_idle_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_inexact && !out_invalid && !out_except));

   p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 3'b111) |=>
         (out_except && out_int == '0 && !out_invalid && !out_inexact));

   p_exact_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 3'b101 && legal_cnt) |=> (out_except == out_inexact));

   p_no_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode != 3'b101 && in_mode != 3'b111 && legal_cnt) |=> !out_except);
endmodule

bind f2i_convert f2i_convert_chk #(
   .MAX_LANES(MAX_LANES),
   .OUT_W    (OUT_W),
   .LC_W     (LC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_mode    (in_mode),
   .in_lanes   (in_lanes),
   .out_valid  (out_valid),
   .out_int    (out_int),
   .out_inexact(out_inexact),
   .out_invalid(out_invalid),
   .out_except (out_except)
);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;
   localparam int NL     = 4;
   localparam int W      = 32;
   localparam int WD_CYC = 100000;

   logic              clk;
   logic              rst_n;
   logic              in_valid;
   logic [2:0]        in_mode;
   logic [1:0]        in_lanes;
   logic              in_dbl;
   logic [NL*64-1:0]  in_opnd;
   logic              out_valid;
   logic [NL*W-1:0]   out_int;
   logic              out_inexact;
   logic              out_invalid;
   logic              out_except;

   int n_chk;
   int n_fail;
   real             lv   [NL];
   bit              lsp  [NL];
   bit              lneg [NL];
   logic [63:0]     lbits[NL];
   logic [NL*W-1:0] last_int;

   f2i_convert #(.MAX_LANES(NL), .OUT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_lanes(in_lanes), .in_dbl(in_dbl), .in_opnd(in_opnd),
      .out_valid(out_valid), .out_int(out_int), .out_inexact(out_inexact),
      .out_invalid(out_invalid), .out_except(out_except)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [NL*W-1:0] act, input logic [NL*W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic logic [31:0] sp_bits(input real v);
      real m;
      int  e;
      logic s;
      s = (v < 0.0);
      m = s ? -v : v;
      e = 0;
      if (m == 0.0) return {s, 31'd0};
      while (m >= 2.0) begin m = m / 2.0; e++; end
      while (m < 1.0)  begin m = m * 2.0; e--; end
      return {s, 8'(e + 127), 23'($rtoi((m - 1.0) * 8388608.0))};
   endfunction

   function automatic int lane_rm(input int mode, input int lc, input int i);
      if (mode == 5) return 0;
      if (mode == 6) begin
         if (lc == 1) return (i == 0) ? 3 : 2;
         case (i % 4)
            0: return 3;
            1: return 0;
            2: return 2;
            default: return 1;
         endcase
      end
      return mode;
   endfunction

   function automatic void ref_lane(input real v, input bit special, input bit neg,
                                    input int rm, output int res, output bit ix, output bit iv);
      real t, f, af, r, sg;
      bit  odd;
      if (special) begin
         iv = 1; ix = 0;
         res = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
         return;
      end
      t  = (v >= 0.0) ? $floor(v) : $ceil(v);
      f  = v - t;
      af = (f < 0.0) ? -f : f;
      sg = (v < 0.0) ? -1.0 : 1.0;
      odd = (t - 2.0 * $floor(t / 2.0)) != 0.0;
      case (rm)
         1: r = t;
         2: r = (f > 0.0) ? t + 1.0 : t;
         3: r = (f < 0.0) ? t - 1.0 : t;
         4: r = (af >= 0.5) ? t + sg : t;
         default: r = (af > 0.5 || (af == 0.5 && odd)) ? t + sg : t;
      endcase
      ix = (af != 0.0);
      iv = 0;
      if (r > 2147483647.0 || r < -2147483648.0) begin
         iv = 1; ix = 0;
         res = (v < 0.0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end else begin
         res = $rtoi(r);
      end
   endfunction

   task automatic set_lane(input int i, input real v, input bit dbl);
      lv[i] = v; lsp[i] = 0; lneg[i] = (v < 0.0);
      lbits[i] = dbl ? $realtobits(v) : {32'h0, sp_bits(v)};
   endtask

   task automatic set_special(input int i, input logic [63:0] bits, input bit neg);
      lv[i] = 0.0; lsp[i] = 1; lneg[i] = neg; lbits[i] = bits;
   endtask

   task automatic run_op(input int mode, input int lc, input bit dbl, input string tag);
      logic [NL*W-1:0] e_int;
      bit e_ix, e_iv, e_ex, bad, ix, iv;
      int res;
      @(negedge clk);
      in_valid = 1'b1;
      in_mode  = 3'(mode);
      in_lanes = 2'(lc);
      in_dbl   = dbl;
      in_opnd  = {lbits[3], lbits[2], lbits[1], lbits[0]};
      bad   = (mode == 7) || (lc > 2);
      e_int = '0; e_ix = 0; e_iv = 0;
      if (!bad) begin
         for (int i = 0; i < NL; i++) begin
            if (i < (1 << lc)) begin
               ref_lane(lv[i], lsp[i], lneg[i], lane_rm(mode, lc, i), res, ix, iv);
               e_int[i*W +: W] = res;
               e_ix |= ix;
               e_iv |= iv;
            end
         end
      end
      e_ex = bad || (mode == 5 && e_ix);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, tag, "valid", NL*W'(out_valid), 1);
      chk(out_int == e_int, tag, "int", out_int, e_int);
      chk(out_inexact == e_ix, tag, "inexact", NL*W'(out_inexact), NL*W'(e_ix));
      chk(out_invalid == e_iv, tag, "invalid", NL*W'(out_invalid), NL*W'(e_iv));
      chk(out_except == e_ex, tag, "except", NL*W'(out_except), NL*W'(e_ex));
      last_int = out_int;
   endtask

   function automatic real rand_val();
      int  k, s;
      real v;
      k = int'($urandom_range(1 << 24, 0));
      s = int'($urandom_range(40, 0)) - 10;
      v = real'(k) / (2.0 ** s);
      return ($urandom_range(1, 0) == 1) ? -v : v;
   endfunction

   initial begin : watchdog
      #(WD_CYC * 20);
      n_fail++;
      $display("FAIL watchdog expired, run did not complete");
      finish_up();
   end

   initial begin : main
      void'($urandom(32'd20240611));
      n_chk = 0; n_fail = 0;
      rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_lanes = '0; in_dbl = 1'b0; in_opnd = '0;
      last_int = '0;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(!out_valid && out_int == '0 && !out_inexact && !out_invalid && !out_except,
          "R13", "reset", out_int, '0);
      rst_n = 1'b1;

      // R1 nearest-even
      set_lane(0, 2.5, 1); set_lane(1, 3.5, 1); set_lane(2, -2.5, 1); set_lane(3, 7.0, 1);
      run_op(0, 2, 1, "R1");
      // R12 idle cycle: flags clear, integers held
      @(negedge clk);
      chk(!out_valid && !out_inexact && !out_invalid && !out_except, "R12", "idle flags",
          NL*W'(out_valid), 0);
      chk(out_int == last_int, "R12", "hold", out_int, last_int);

      // R2 toward zero
      set_lane(0, 2.75, 1); set_lane(1, -2.75, 1); set_lane(2, 0.5, 1); set_lane(3, -0.25, 1);
      run_op(1, 2, 1, "R2");
      // R3 directed
      set_lane(0, 2.25, 1); set_lane(1, -2.25, 1); set_lane(2, 0.0, 1); set_lane(3, -0.75, 1);
      run_op(2, 2, 1, "R3");
      run_op(3, 2, 1, "R3");
      // R4 ties away
      set_lane(0, 2.5, 1); set_lane(1, -2.5, 1); set_lane(2, 1.25, 1); set_lane(3, -3.5, 1);
      run_op(4, 2, 1, "R4");
      // R5 exact: inexact lane raises, all-integer does not (R7 inexact clear)
      run_op(5, 2, 1, "R5");
      set_lane(0, 2.0, 1); set_lane(1, -4.0, 1); set_lane(2, 0.0, 1); set_lane(3, 100.0, 1);
      run_op(5, 2, 1, "R5");
      run_op(3, 2, 1, "R7");
      // R6 mixed, two and four lanes
      for (int i = 0; i < NL; i++) set_lane(i, 2.5, 1);
      run_op(6, 1, 1, "R6");
      run_op(6, 2, 1, "R6");
      for (int i = 0; i < NL; i++) set_lane(i, -2.5, 1);
      run_op(6, 2, 1, "R6");
      run_op(6, 0, 1, "R6");
      // R8 specials and range
      set_special(0, 64'h7FF0_0000_0000_0000, 0);
      set_special(1, 64'hFFF0_0000_0000_0000, 1);
      set_special(2, 64'h7FF8_0000_0000_0000, 0);
      set_lane(3, 3.0e9, 1);
      run_op(0, 2, 1, "R8");
      set_lane(0, -2147483648.0, 1); set_lane(1, 2147483647.5, 1);
      set_lane(2, -2147483648.5, 1); set_lane(3, -3.0e9, 1);
      run_op(0, 2, 1, "R8");
      run_op(1, 2, 1, "R8");
      set_special(0, 64'h0000_0000_7F80_0000, 0);
      set_lane(1, 1.5, 0); set_lane(2, 0.0, 0); set_lane(3, 0.0, 0);
      run_op(0, 2, 0, "R8");
      // R9 illegal code and lane count
      for (int i = 0; i < NL; i++) set_lane(i, 2.5, 1);
      run_op(7, 2, 1, "R9");
      run_op(0, 3, 1, "R9");
      // R10 single precision
      set_lane(0, 5.5, 0); set_lane(1, -0.375, 0); set_lane(2, 1048575.5, 0); set_lane(3, -12.0, 0);
      run_op(0, 2, 0, "R10");
      run_op(2, 2, 0, "R10");
      // R11 lane count masking
      set_lane(0, 4.0, 1); set_lane(1, 2.5, 1); set_lane(2, 9.75, 1); set_lane(3, 1.0e12, 1);
      run_op(0, 0, 1, "R11");
      run_op(5, 0, 1, "R11");
      run_op(0, 1, 1, "R11");

      // constrained random, all requirements
      for (int n = 0; n < 400; n++) begin
         bit dbl;
         int mode, lc;
         dbl  = ($urandom_range(1, 0) == 1);
         mode = int'($urandom_range(7, 0));
         lc   = ($urandom_range(15, 0) == 0) ? 3 : int'($urandom_range(2, 0));
         for (int i = 0; i < NL; i++) set_lane(i, rand_val(), dbl);
         run_op(mode, lc, dbl, "R1-random");
      end

      finish_up();
   end
endmodule